// File: doc/BRIEF.md
# Scanout Start Address and Buffer Flip Unit

This block produces the memory address of the line that the graphics fetch engine reads next. From the buffer base address, the line pitch in bytes, an x/y pan offset and the pixel size in bytes, it derives a start address for each field and a line stride. In interlaced operation the two fields start one pitch apart and the stride is doubled. In progressive operation both fields share one start address and the stride equals the pitch. A line walker reloads the field start at each field-start pulse and steps by the stride at each line-end pulse.

Buffer changes arrive as flip requests on a valid/ready channel. Back-pressure follows two rules. `flip_ready` is high only while no flip is held. A request is taken on a clock edge where `flip_valid` and `flip_ready` are both high. While `flip_ready` is low, the address on `flip_base` is ignored, and a requester that still wants the flip must keep `flip_valid` high until it is taken.

A flip that has been taken stays held and is committed at the next field end, or on the next clock if the display is blanked, because a blanked display produces no field ends. On commit the new base replaces the old one, `busy` falls and `flip_done` pulses for one cycle. Until the first flip commits, the base comes from `cfg_base`.

Top module: `scan_addr_flip`

## Requirements
- R1: While reset is asserted, `line_addr` is 0, `busy` is 0, `flip_done` is 0 and `flip_ready` is 1.
- R2: The start offset is `cfg_y*cfg_pitch + cfg_x*cfg_bpp`, added to the active base. `cfg_bpp` holds the pixel size as a plain byte count (1 to 4). `cfg_pitch` is 16 bits wide.
- R3: With `cfg_interlace`=0, both fields use the same start address and a line end advances `line_addr` by `cfg_pitch`.
- R4: With `cfg_interlace`=1, the field start for `field_odd`=1 is base+offset and for `field_odd`=0 it is base+offset+`cfg_pitch`. A line end advances `line_addr` by 2*`cfg_pitch`.
- R5: A `field_start` pulse loads the start address of the field selected by `field_odd` into `line_addr` on the next edge. A `line_end` pulse adds the stride. When both pulses arrive in the same cycle, `field_start` wins.
- R6: `flip_ready` equals the inverse of `busy`. A request taken on an edge sets `busy` from the next cycle.
- R7: A request presented while `busy`=1 is refused, and its `flip_base` never becomes the active base.
- R8: A held flip commits on the edge where `field_end`=1. On that edge the held base becomes active, `busy` falls and `flip_done` is 1 for exactly one cycle. A `field_start` on the same edge already uses the new base.
- R9: While `blanked`=1, a held flip commits on the edge after it was taken, without any `field_end`.
- R10: Before any flip has committed, the active base follows `cfg_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_base | input | AW | Base address used until the first flip |
| cfg_pitch | input | PW | Line pitch in bytes |
| cfg_x | input | XW | Horizontal pan in pixels |
| cfg_y | input | YW | Vertical pan in lines |
| cfg_bpp | input | 3 | Bytes per pixel, 1 to 4 |
| cfg_interlace | input | 1 | 1 selects interlaced field addressing |
| flip_valid | input | 1 | Flip request valid |
| flip_base | input | AW | New buffer base carried by the request |
| flip_ready | output | 1 | High while a request can be taken |
| blanked | input | 1 | Display blanked; commits a held flip at once |
| field_end | input | 1 | End-of-field pulse from the timing generator |
| field_start | input | 1 | Start-of-field pulse from the timing generator |
| field_odd | input | 1 | Field index, 1 for the odd field |
| line_end | input | 1 | End-of-line pulse |
| line_addr | output | AW | Start address of the current line |
| busy | output | 1 | A flip is held and not yet committed |
| flip_done | output | 1 | One-cycle pulse on the cycle the new base becomes active |

## Verification
Two collisions can happen on a single clock edge. The first is a flip commit at field end together with the field-start reload. The second is a line-end step together with a field-start reload. The bench pulses `field_end` and `field_start` together while a flip is held, and expects `line_addr` to jump straight to the new buffer's field start in the same cycle that `flip_done` rises. It also pulses `line_end` and `field_start` together and expects the reload to win over the step. A behavioural reference model, updated on every edge, gives the expected value of each output at each falling edge.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic {
    FLD_EVEN = 1'b0,
    FLD_ODD  = 1'b1
  } field_e;

  typedef enum logic {
    HOLD_EMPTY = 1'b0,
    HOLD_FULL  = 1'b1
  } hold_e;
endpackage

// File: rtl/scan_start_calc.sv
module scan_start_calc #(
  parameter int AW = 32,
  parameter int PW = 16,
  parameter int XW = 12,
  parameter int YW = 12
) (
  input  logic [AW-1:0] base,
  input  logic [PW-1:0] pitch,
  input  logic [XW-1:0] pan_x,
  input  logic [YW-1:0] pan_y,
  input  logic [2:0]    bpp,
  input  logic          interlace,
  output logic [AW-1:0] odd_start,
  output logic [AW-1:0] even_start,
  output logic [AW-1:0] stride
);
  logic [AW-1:0] pitch_w;
  logic [AW-1:0] row_off;
  logic [AW-1:0] col_off;
  logic [AW-1:0] first;

  always_comb begin
    pitch_w    = AW'(pitch);
    row_off    = AW'(pan_y) * pitch_w;
    col_off    = AW'(pan_x) * AW'(bpp);
    first      = base + row_off + col_off;
    odd_start  = first;
    even_start = interlace ? first + pitch_w : first;
    stride     = interlace ? (pitch_w << 1) : pitch_w;
  end
endmodule

// File: rtl/scan_flip_ctrl.sv
module scan_flip_ctrl
  import scan_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic          flip_valid,
  input  logic [AW-1:0] flip_base,
  input  logic          blanked,
  input  logic          field_end,
  output logic          flip_ready,
  output logic          busy,
  output logic          flip_done,
  output logic [AW-1:0] base_now
);
  hold_e         hold_q;
  logic [AW-1:0] held_base;
  logic [AW-1:0] act_base;
  logic          swapped;
  logic          commit;
  logic          accept;

  always_comb begin
    commit     = (hold_q == HOLD_FULL) && (field_end || blanked);
    accept     = flip_valid && (hold_q == HOLD_EMPTY);
    flip_ready = (hold_q == HOLD_EMPTY);
    busy       = (hold_q == HOLD_FULL);
    if (commit)       base_now = held_base;
    else if (swapped) base_now = act_base;
    else              base_now = cfg_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= HOLD_EMPTY;
      held_base <= '0;
      act_base  <= '0;
      swapped   <= 1'b0;
      flip_done <= 1'b0;
    end else begin
      flip_done <= commit;
      if (commit) begin
        act_base <= held_base;
        swapped  <= 1'b1;
        hold_q   <= HOLD_EMPTY;
      end else if (accept) begin
        held_base <= flip_base;
        hold_q    <= HOLD_FULL;
      end
    end
  end
endmodule

// File: rtl/scan_line_walker.sv
module scan_line_walker
  import scan_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          field_start,
  input  logic          line_end,
  input  logic          field_odd,
  input  logic [AW-1:0] odd_start,
  input  logic [AW-1:0] even_start,
  input  logic [AW-1:0] stride,
  output logic [AW-1:0] line_addr
);
  field_e        fld;
  logic [AW-1:0] start_sel;

  always_comb begin
    fld       = field_e'(field_odd);
    start_sel = (fld == FLD_ODD) ? odd_start : even_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           line_addr <= '0;
    else if (field_start) line_addr <= start_sel;
    else if (line_end)    line_addr <= line_addr + stride;
  end
endmodule

// File: rtl/scan_addr_flip.sv
module scan_addr_flip #(
  parameter int AW = 32,
  parameter int PW = 16,
  parameter int XW = 12,
  parameter int YW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic [PW-1:0] cfg_pitch,
  input  logic [XW-1:0] cfg_x,
  input  logic [YW-1:0] cfg_y,
  input  logic [2:0]    cfg_bpp,
  input  logic          cfg_interlace,
  input  logic          flip_valid,
  input  logic [AW-1:0] flip_base,
  output logic          flip_ready,
  input  logic          blanked,
  input  logic          field_end,
  input  logic          field_start,
  input  logic          field_odd,
  input  logic          line_end,
  output logic [AW-1:0] line_addr,
  output logic          busy,
  output logic          flip_done
);
  logic [AW-1:0] base_now;
  logic [AW-1:0] odd_start;
  logic [AW-1:0] even_start;
  logic [AW-1:0] stride;

  scan_flip_ctrl #(.AW(AW)) u_flip (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base),
    .flip_valid(flip_valid), .flip_base(flip_base),
    .blanked(blanked), .field_end(field_end),
    .flip_ready(flip_ready), .busy(busy), .flip_done(flip_done),
    .base_now(base_now)
  );

  scan_start_calc #(.AW(AW), .PW(PW), .XW(XW), .YW(YW)) u_calc (
    .base(base_now), .pitch(cfg_pitch), .pan_x(cfg_x), .pan_y(cfg_y),
    .bpp(cfg_bpp), .interlace(cfg_interlace),
    .odd_start(odd_start), .even_start(even_start), .stride(stride)
  );

  scan_line_walker #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .field_start(field_start),
    .line_end(line_end), .field_odd(field_odd),
    .odd_start(odd_start), .even_start(even_start), .stride(stride),
    .line_addr(line_addr)
  );
endmodule

// File: rtl/scan_addr_flip_chk.sv
module scan_addr_flip_chk #(
  parameter int AW = 32,
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flip_valid,
  input logic          flip_ready,
  input logic          busy,
  input logic          flip_done,
  input logic          blanked,
  input logic          field_end,
  input logic          field_start,
  input logic          line_end,
  input logic          cfg_interlace,
  input logic [PW-1:0] cfg_pitch,
  input logic [AW-1:0] line_addr
);
  p_take_sets_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flip_valid && flip_ready |=> busy);

  p_hold_until_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !field_end && !blanked |=> busy && !flip_done);

  p_done_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flip_done |-> !busy && $past(busy));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flip_done |=> !flip_done);

  p_blank_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && blanked |=> flip_done);

  p_prog_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    line_end && !field_start && !cfg_interlace
      |=> line_addr == $past(line_addr) + AW'($past(cfg_pitch)));

  p_intl_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    line_end && !field_start && cfg_interlace
      |=> line_addr == $past(line_addr) + (AW'($past(cfg_pitch)) << 1));
endmodule

bind scan_addr_flip scan_addr_flip_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flip_valid(flip_valid), .flip_ready(flip_ready),
  .busy(busy), .flip_done(flip_done), .blanked(blanked),
  .field_end(field_end), .field_start(field_start), .line_end(line_end),
  .cfg_interlace(cfg_interlace), .cfg_pitch(cfg_pitch), .line_addr(line_addr)
);

// File: tb/test_scan_addr_flip.sv
module test_scan_addr_flip;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_base = 32'h1000_0000;
  logic [15:0] cfg_pitch = 16'd2560;
  logic [11:0] cfg_x = '0;
  logic [11:0] cfg_y = '0;
  logic [2:0]  cfg_bpp = 3'd4;
  logic        cfg_interlace = 1'b0;
  logic        flip_valid = 1'b0;
  logic [31:0] flip_base = '0;
  logic        flip_ready;
  logic        blanked = 1'b0;
  logic        field_end = 1'b0;
  logic        field_start = 1'b0;
  logic        field_odd = 1'b1;
  logic        line_end = 1'b0;
  logic [31:0] line_addr;
  logic        busy;
  logic        flip_done;

  int    checks = 0;
  int    bad = 0;
  int    cycles = 0;
  bit    finished = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_addr_flip i_scan_addr_flip (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_pitch(cfg_pitch),
    .cfg_x(cfg_x), .cfg_y(cfg_y), .cfg_bpp(cfg_bpp),
    .cfg_interlace(cfg_interlace), .flip_valid(flip_valid),
    .flip_base(flip_base), .flip_ready(flip_ready), .blanked(blanked),
    .field_end(field_end), .field_start(field_start), .field_odd(field_odd),
    .line_end(line_end), .line_addr(line_addr), .busy(busy),
    .flip_done(flip_done)
  );

  // behavioural reference model
  logic [31:0] m_line, m_pbase, m_abase, m_base, m_off, m_p;
  bit          m_pend, m_flipped, m_done, m_commit, m_take;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_line = 0; m_pbase = 0; m_abase = 0;
      m_pend = 0; m_flipped = 0; m_done = 0;
    end else begin
      m_commit = m_pend && (field_end || blanked);
      m_take   = flip_valid && !m_pend;
      m_done   = m_commit;
      if (m_commit) begin
        m_abase = m_pbase; m_flipped = 1; m_pend = 0;
      end else if (m_take) begin
        m_pbase = flip_base; m_pend = 1;
      end
      m_base = m_flipped ? m_abase : cfg_base;
      m_p    = 32'(cfg_pitch);
      m_off  = 32'(cfg_y) * m_p + 32'(cfg_x) * 32'(cfg_bpp);
      if (field_start)
        m_line = m_base + m_off + ((cfg_interlace && !field_odd) ? m_p : 0);
      else if (line_end)
        m_line = m_line + (cfg_interlace ? 2 * m_p : m_p);
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("line_addr", line_addr, m_line);
      chk("busy", 32'(busy), 32'(m_pend));
      chk("flip_done", 32'(flip_done), 32'(m_done));
      chk("flip_ready", 32'(flip_ready), 32'(!m_pend));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic fstart(bit odd);
    field_odd = odd; field_start = 1; tick(); field_start = 0;
  endtask

  task automatic lines(int n);
    line_end = 1; tick(n); line_end = 0; tick();
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      checks++; bad++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      finish_run();
    end
  end

  initial begin
    tick(3);
    phase = "R1";
    chk("reset line_addr", line_addr, 0);
    chk("reset busy", 32'(busy), 0);
    chk("reset flip_done", 32'(flip_done), 0);
    chk("reset flip_ready", 32'(flip_ready), 1);
    rst_n = 1; tick(2);

    // R2 / R10: offset arithmetic on cfg_base, several pixel sizes
    phase = "R2";
    cfg_x = 12'd5; cfg_y = 12'd3;
    fstart(1);
    chk("R2 start bpp4", line_addr, 32'h1000_0000 + 3*2560 + 5*4);
    cfg_bpp = 3'd1; fstart(1);
    chk("R2 start bpp1", line_addr, 32'h1000_0000 + 3*2560 + 5);
    cfg_bpp = 3'd3; cfg_pitch = 16'hFFFF; cfg_y = 12'd2; fstart(0);
    chk("R2 wide pitch", line_addr, 32'h1000_0000 + 2*65535 + 15);
    phase = "R10";
    cfg_base = 32'h2000_0000; cfg_bpp = 3'd2; cfg_pitch = 16'd1024; fstart(1);
    chk("R10 cfg_base follows", line_addr, 32'h2000_0000 + 2*1024 + 10);

    // R3: progressive, both fields equal, stride = pitch
    phase = "R3";
    fstart(0);
    chk("R3 even equals odd", line_addr, 32'h2000_0000 + 2*1024 + 10);
    lines(3);
    chk("R3 three lines", line_addr, 32'h2000_0000 + 5*1024 + 10);

    // R5: field_start wins over line_end
    phase = "R5";
    line_end = 1; field_start = 1; field_odd = 1; tick();
    line_end = 0; field_start = 0;
    chk("R5 reload wins", line_addr, 32'h2000_0000 + 2*1024 + 10);

    // R4: interlaced
    phase = "R4";
    cfg_interlace = 1; fstart(1);
    chk("R4 odd start", line_addr, 32'h2000_0000 + 2*1024 + 10);
    fstart(0);
    chk("R4 even start", line_addr, 32'h2000_0000 + 3*1024 + 10);
    lines(2);
    chk("R4 double stride", line_addr, 32'h2000_0000 + 7*1024 + 10);

    // R6: request taken, busy follows
    phase = "R6";
    flip_base = 32'h3000_0000; flip_valid = 1; tick(); flip_valid = 0;
    chk("R6 busy after take", 32'(busy), 1);
    tick(3);

    // R7: request while busy is refused
    phase = "R7";
    flip_base = 32'h4000_0000; flip_valid = 1; tick(2); flip_valid = 0;
    chk("R7 still not ready", 32'(flip_ready), 0);

    // R8: commit on field_end together with field_start
    phase = "R8";
    field_end = 1; field_start = 1; field_odd = 1; tick();
    field_end = 0; field_start = 0;
    chk("R8 flip_done", 32'(flip_done), 1);
    chk("R7 first base kept", line_addr, 32'h3000_0000 + 2*1024 + 10);
    tick();
    chk("R8 done one cycle", 32'(flip_done), 0);
    cfg_base = 32'h5000_0000; fstart(0);
    chk("R8 flipped base stays", line_addr, 32'h3000_0000 + 3*1024 + 10);

    // R9: blanked commit
    phase = "R9";
    blanked = 1; flip_base = 32'h6000_0000; flip_valid = 1; tick();
    flip_valid = 0;
    chk("R9 busy one cycle", 32'(busy), 1);
    tick();
    chk("R9 done without field_end", 32'(flip_done), 1);
    blanked = 0; cfg_interlace = 0; fstart(1);
    chk("R9 new base", line_addr, 32'h6000_0000 + 2*1024 + 10);
    lines(4);
    tick(2);
    finish_run();
  end
endmodule